// File: doc/BRIEF.md
# External Memory Interface Controller

This block turns data-move requests from a processor core into accesses to either a small on-chip scratch RAM or an off-chip parallel memory. Each request carries a 16-bit address, a flag that says whether the address is a full 16-bit pointer or an 8-bit offset, a read/write flag and one byte of write data. The block takes a configuration byte, a bank byte and the value of the address-high port latch as inputs. From these it forms the effective address, chooses the target and runs the access.

A 2-bit routing mode selects the target. In internal mode every access goes on-chip. In the two split modes, effective addresses below 0x0100 go on-chip and all others go off-chip. In external mode every access goes off-chip. The two split modes differ only in where an 8-bit access gets its upper address byte. Off-chip cycles can use one of two bus formats. The multiplexed format shares the low address byte and the data on one bus and uses an address-latch-enable (ALE) phase whose width can be programmed. The separate format has dedicated address pins and no ALE phase.

Top module: `emif_ctrl`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `done_o`, `ale_o`, `ext_rd_o`, `ext_wr_o`, `ad_oe_o` and `ram_en_o` are all 0.
- R2: Routing mode `cfg_i[3:2]=00` sends every access on-chip. Exactly one `ram_en_o` cycle occurs, no external strobe occurs, `ram_addr_o` equals the low `RAM_AW` bits of the effective address, and `ram_we_o` equals the write flag.
- R3: In routing modes `01` and `10`, an access goes on-chip when the 16-bit effective address is below 0x0100 and off-chip otherwise.
- R4: The effective upper byte is `addr_i[15:8]` when `wide_i=1`. When `wide_i=0` it is `port_hi_i` in mode `01` and `bank_i` in every other mode. The effective low byte is always `addr_i[7:0]`.
- R5: Routing mode `11` sends every access off-chip and never asserts `ram_en_o`.
- R6: With `cfg_i[4]=0` (multiplexed bus), an off-chip access holds `ale_o` high for W cycles and then low for W cycles before the strobe, where W = `cfg_i[1:0]`+1. During the ALE phases `ad_o` carries the effective low byte and `ad_oe_o` is 1.
- R7: With `cfg_i[4]=1` (separate bus), `ale_o` stays low, the strobe occurs in the first cycle after acceptance, and `addr_lo_o` carries the effective low byte.
- R8: A request is accepted only when `busy_o` is 0. `busy_o` stays high from the cycle after acceptance through the single-cycle `done_o` pulse. It lasts 2 cycles for on-chip and separate-bus accesses and 2W+2 cycles for multiplexed off-chip accesses. An off-chip access has exactly one single-cycle strobe.
- R9: Read data is sampled at the end of the read strobe (`ad_i`) or the on-chip cycle (`ram_rdata_i`) and is presented on `rdata_o` during `done_o`.
- R10: During a write strobe, `ad_oe_o`=1 and `ad_o` equals the write data. During a read strobe `ad_oe_o`=0.
- R11: `cfg_i[7:5]` has no effect, and request inputs presented while `busy_o` is high are ignored.
- R12: `addr_hi_o` equals the effective upper byte during the strobe of every off-chip access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| wide_i | input | 1 | 1: 16-bit address, 0: 8-bit offset |
| wr_i | input | 1 | 1: write, 0: read |
| addr_i | input | 16 | Request address |
| wdata_i | input | 8 | Write data |
| cfg_i | input | 8 | Configuration: [4] separate bus, [3:2] routing mode, [1:0] ALE width code |
| bank_i | input | 8 | Bank register |
| port_hi_i | input | 8 | Address-high port latch value |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Access complete, one cycle |
| rdata_o | output | 8 | Read data, valid with done_o |
| ram_en_o | output | 1 | On-chip RAM access enable |
| ram_we_o | output | 1 | On-chip RAM write enable |
| ram_addr_o | output | 10 | On-chip RAM address |
| ram_wdata_o | output | 8 | On-chip RAM write data |
| ram_rdata_i | input | 8 | On-chip RAM read data (asynchronous) |
| ale_o | output | 1 | Address latch enable |
| ext_rd_o | output | 1 | External read strobe, active high |
| ext_wr_o | output | 1 | External write strobe, active high |
| ad_o | output | 8 | Shared address/data bus, output side |
| ad_oe_o | output | 1 | Output enable for ad_o |
| ad_i | input | 8 | Shared bus, input side |
| addr_lo_o | output | 8 | Dedicated low address pins |
| addr_hi_o | output | 8 | High address pins |

## Verification
The assertions check on every cycle the following properties:
- The ALE high and low widths match the latched width code.
- `ale_o` appears only on the multiplexed bus.
- On-chip cycles never coincide with external strobes.
- The bus is never driven during a read strobe.
- `done_o` is always followed by idle.
- Internal and external routing modes always pick their fixed target.

The split-boundary decision, the choice of upper-byte source and the values of the address and data bytes can only be shown by the bench. It sweeps every mode, bus format and width code over addresses on both sides of 0x0100, and it compares every byte with values it computes itself.

// File: rtl/emif_pkg.sv
package emif_pkg;
  typedef enum logic [1:0] {
    MODE_INT        = 2'b00,
    MODE_SPLIT_PORT = 2'b01,
    MODE_SPLIT_BANK = 2'b10,
    MODE_EXT        = 2'b11
  } route_mode_e;

  typedef struct packed {
    logic [2:0]  rsvd;
    logic        sep_bus;
    route_mode_e mode;
    logic [1:0]  ale_w;
  } cfg_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RAM, S_ALE_H, S_ALE_L, S_STROBE, S_DONE
  } seq_state_e;
endpackage

// File: rtl/emif_addr_map.sv
module emif_addr_map
  import emif_pkg::*;
#(
  parameter int AW    = 16,
  parameter int SPLIT = 256,
  localparam int HW   = AW - 8
) (
  input  route_mode_e   mode_i,
  input  logic          wide_i,
  input  logic [AW-1:0] addr_i,
  input  logic [HW-1:0] bank_i,
  input  logic [HW-1:0] port_hi_i,
  output logic [AW-1:0] eff_o,
  output logic          off_o
);
  logic [HW-1:0] hi;

  always_comb begin
    if (wide_i)                       hi = addr_i[AW-1:8];
    else if (mode_i == MODE_SPLIT_PORT) hi = port_hi_i;
    else                              hi = bank_i;
  end

  assign eff_o = {hi, addr_i[7:0]};

  always_comb begin
    unique case (mode_i)
      MODE_INT:  off_o = 1'b0;
      MODE_EXT:  off_o = 1'b1;
      default:   off_o = (eff_o >= AW'(SPLIT));
    endcase
  end
endmodule

// File: rtl/emif_bus_seq.sv
module emif_bus_seq
  import emif_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int RAM_AW = 10,
  parameter int CW     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              go_off_i,
  input  logic              go_mux_i,
  input  logic [CW-1:0]     width_q_i,
  input  logic              wr_q_i,
  input  logic [AW-1:0]     eff_q_i,
  input  logic [DW-1:0]     wdata_q_i,
  input  logic [DW-1:0]     ad_i,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ale_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DW-1:0]     ad_o,
  output logic              ad_oe_o,
  output logic [7:0]        addr_lo_o,
  output logic [AW-9:0]     addr_hi_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [DW-1:0]     ram_wdata_o,
  output logic [DW-1:0]     rdata_o
);
  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          strobe;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      S_IDLE:
        if (start_i) begin
          if (!go_off_i)     state_d = S_RAM;
          else if (go_mux_i) state_d = S_ALE_H;
          else               state_d = S_STROBE;
          cnt_d = '0;
        end
      S_RAM: state_d = S_DONE;
      S_ALE_H:
        if (cnt_q == width_q_i) begin
          cnt_d   = '0;
          state_d = S_ALE_L;
        end else cnt_d = cnt_q + 1'b1;
      S_ALE_L:
        if (cnt_q == width_q_i) begin
          cnt_d   = '0;
          state_d = S_STROBE;
        end else cnt_d = cnt_q + 1'b1;
      S_STROBE: state_d = S_DONE;
      S_DONE:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      rdata_o <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == S_RAM && !wr_q_i)    rdata_o <= ram_rdata_i;
      if (state_q == S_STROBE && !wr_q_i) rdata_o <= ad_i;
    end
  end

  assign strobe      = (state_q == S_STROBE);
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign ale_o       = (state_q == S_ALE_H);
  assign rd_o        = strobe && !wr_q_i;
  assign wr_o        = strobe && wr_q_i;
  assign ad_oe_o     = (state_q == S_ALE_H) || (state_q == S_ALE_L) || wr_o;
  assign ad_o        = strobe ? wdata_q_i : eff_q_i[7:0];
  assign addr_lo_o   = eff_q_i[7:0];
  assign addr_hi_o   = eff_q_i[AW-1:8];
  assign ram_en_o    = (state_q == S_RAM);
  assign ram_we_o    = ram_en_o && wr_q_i;
  assign ram_addr_o  = eff_q_i[RAM_AW-1:0];
  assign ram_wdata_o = wdata_q_i;
endmodule

// File: rtl/emif_ctrl.sv
module emif_ctrl
  import emif_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int RAM_AW = 10,
  parameter int SPLIT  = 256,
  localparam int HW    = AW - 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wide_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [7:0]        cfg_i,
  input  logic [HW-1:0]     bank_i,
  input  logic [HW-1:0]     port_hi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [DW-1:0]     ram_wdata_o,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic              ale_o,
  output logic              ext_rd_o,
  output logic              ext_wr_o,
  output logic [DW-1:0]     ad_o,
  output logic              ad_oe_o,
  input  logic [DW-1:0]     ad_i,
  output logic [7:0]        addr_lo_o,
  output logic [HW-1:0]     addr_hi_o
);
  cfg_t          cfg;
  logic          start;
  logic [AW-1:0] eff_d, eff_q;
  logic          off_d, off_q;
  logic          mux_q, wr_q;
  logic [1:0]    width_q;
  logic [DW-1:0] wdata_q;

  assign cfg   = cfg_t'(cfg_i);
  assign start = req_i && !busy_o;

  emif_addr_map #(.AW(AW), .SPLIT(SPLIT)) u_map (
    .mode_i    (cfg.mode),
    .wide_i    (wide_i),
    .addr_i    (addr_i),
    .bank_i    (bank_i),
    .port_hi_i (port_hi_i),
    .eff_o     (eff_d),
    .off_o     (off_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q   <= '0;
      off_q   <= 1'b0;
      mux_q   <= 1'b0;
      wr_q    <= 1'b0;
      width_q <= '0;
      wdata_q <= '0;
    end else if (start) begin
      eff_q   <= eff_d;
      off_q   <= off_d;
      mux_q   <= !cfg.sep_bus;
      wr_q    <= wr_i;
      width_q <= cfg.ale_w;
      wdata_q <= wdata_i;
    end
  end

  emif_bus_seq #(.AW(AW), .DW(DW), .RAM_AW(RAM_AW), .CW(2)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .go_off_i    (off_d),
    .go_mux_i    (!cfg.sep_bus),
    .width_q_i   (width_q),
    .wr_q_i      (wr_q),
    .eff_q_i     (eff_q),
    .wdata_q_i   (wdata_q),
    .ad_i        (ad_i),
    .ram_rdata_i (ram_rdata_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ale_o       (ale_o),
    .rd_o        (ext_rd_o),
    .wr_o        (ext_wr_o),
    .ad_o        (ad_o),
    .ad_oe_o     (ad_oe_o),
    .addr_lo_o   (addr_lo_o),
    .addr_hi_o   (addr_hi_o),
    .ram_en_o    (ram_en_o),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/emif_ctrl_chk.sv
module emif_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start,
  input logic [7:0] cfg_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       ale_o,
  input logic       ext_rd_o,
  input logic       ext_wr_o,
  input logic       ad_oe_o,
  input logic       ram_en_o,
  input logic       mux_q,
  input logic [1:0] width_q
);
  logic [2:0] hi_cnt, lo_cnt;
  logic       strobe;

  assign strobe = ext_rd_o || ext_wr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= ale_o ? hi_cnt + 3'd1 : 3'd0;
      lo_cnt <= (busy_o && !ale_o && !strobe && !done_o) ? lo_cnt + 3'd1 : 3'd0;
    end
  end

  assert_ale_high_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> hi_cnt == {1'b0, width_q} + 3'd1);

  assert_ale_low_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe) |-> lo_cnt == (mux_q ? {1'b0, width_q} + 3'd1 : 3'd0));

  assert_no_ale_sep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> mux_q);

  assert_ram_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> !(strobe || ale_o));

  assert_int_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && cfg_i[3:2] == 2'b00) |=> ram_en_o);

  assert_ext_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && cfg_i[3:2] == 2'b11) |=> !ram_en_o);

  assert_read_hiz_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rd_o |-> !ad_oe_o);

  assert_strobe_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |=> !strobe && done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  assert_strobe_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ext_rd_o, ext_wr_o, ram_en_o}));
endmodule

bind emif_ctrl emif_ctrl_chk u_chk (.*);

// File: tb/tb_emif_ctrl.sv
module tb_emif_ctrl;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic        req_i = 0, wide_i = 0, wr_i = 0;
  logic [15:0] addr_i = 0;
  logic [7:0]  wdata_i = 0, cfg_i = 8'h03, bank_i = 0, port_hi_i = 0;
  logic        busy_o, done_o, ram_en_o, ram_we_o, ale_o, ext_rd_o, ext_wr_o, ad_oe_o;
  logic [7:0]  rdata_o, ram_wdata_o, ram_rdata_i, ad_o, ad_i, addr_lo_o, addr_hi_o;
  logic [9:0]  ram_addr_o;
  logic [7:0]  lat_lo = 0;
  logic        tb_mux = 1'b1;

  int n_chk = 0, n_fail = 0;

  function automatic logic [7:0] ext_fn(input logic [7:0] hi, input logic [7:0] lo);
    return hi ^ {lo[3:0], lo[7:4]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] ram_fn(input logic [9:0] a);
    return a[7:0] ^ {6'b0, a[9:8]} ^ 8'hC3;
  endfunction

  assign ram_rdata_i = ram_fn(ram_addr_o);
  assign ad_i = ext_fn(addr_hi_o, tb_mux ? lat_lo : addr_lo_o);
  always @(posedge clk_i) if (ale_o) lat_lo <= ad_o;

  emif_ctrl dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run(input logic [7:0] cfg, input bit wide, input bit wr,
                     input logic [15:0] addr, input logic [7:0] wd,
                     input logic [7:0] bank, input logic [7:0] port);
    int m, w, exp_busy;
    bit sep, off, got, seen_ale, seen_stb;
    logic [7:0] hi, s_hi, s_lo, s_ado, r_dat;
    logic [15:0] eff;
    logic [9:0] s_ram;
    bit s_oe, s_we;
    int busy_n, ale_h, ale_l, stb_n, ram_n;
    string tag;
    m   = int'(cfg[3:2]);
    sep = cfg[4];
    w   = int'(cfg[1:0]) + 1;
    hi  = wide ? addr[15:8] : (m == 1 ? port : bank);
    eff = {hi, addr[7:0]};
    off = (m == 3) || ((m == 1 || m == 2) && eff >= 16'h0100);
    exp_busy = (off && !sep) ? 2 * w + 2 : 2;
    tag = (m == 0) ? "R2" : (m == 3) ? "R5" : "R3";
    busy_n = 0; ale_h = 0; ale_l = 0; stb_n = 0; ram_n = 0;
    got = 0; seen_ale = 0; seen_stb = 0;
    s_hi = 0; s_lo = 0; s_ado = 0; s_oe = 0; s_we = 0; s_ram = 0; r_dat = 0;

    @(negedge clk_i);
    cfg_i = cfg; bank_i = bank; port_hi_i = port; tb_mux = !sep;
    wide_i = wide; wr_i = wr; addr_i = addr; wdata_i = wd; req_i = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < 40 && !got; k++) begin
      if (busy_o) busy_n++;
      if (ale_o) begin ale_h++; seen_ale = 1; end
      if (seen_ale && !ale_o && busy_o && !ext_rd_o && !ext_wr_o && !seen_stb && !done_o) ale_l++;
      if (ext_rd_o || ext_wr_o) begin
        stb_n++; seen_stb = 1;
        s_hi = addr_hi_o; s_lo = sep ? addr_lo_o : lat_lo;
        s_oe = ad_oe_o; s_ado = ad_o;
      end
      if (ram_en_o) begin ram_n++; s_ram = ram_addr_o; s_we = ram_we_o; end
      if (done_o) begin got = 1; r_dat = rdata_o; end
      // R11: junk request held high while busy
      if (k == 0) begin addr_i = ~addr; wdata_i = ~wd; wr_i = ~wr; end
      if (k == 1) req_i = 1'b0;
      @(negedge clk_i);
    end
    req_i = 1'b0;
    chk("R8 done pulse", int'(got), 1);
    chk("R8 busy length", busy_n, exp_busy);
    chk("R8 R11 idle after done", int'(busy_o), 0);
    chk(sep ? "R7 ale high" : "R6 ale high", ale_h, (off && !sep) ? w : 0);
    if (off && !sep) chk("R6 ale low", ale_l, w);
    chk({tag, " ram cycles"}, ram_n, off ? 0 : 1);
    chk({tag, " strobes"}, stb_n, off ? 1 : 0);
    if (!off) begin
      chk("R2 R4 R11 ram addr", int'(s_ram), int'(eff[9:0]));
      chk("R2 ram we", int'(s_we), int'(wr));
    end else begin
      chk("R12 R4 addr hi", int'(s_hi), int'(hi));
      chk(sep ? "R7 R11 addr lo" : "R6 R11 addr lo", int'(s_lo), int'(addr[7:0]));
      chk("R10 oe at strobe", int'(s_oe), int'(wr));
      if (wr) chk("R10 write data", int'(s_ado), int'(wd));
    end
    if (!wr) chk("R9 read data", int'(r_dat),
                 off ? int'(ext_fn(hi, addr[7:0])) : int'(ram_fn(eff[9:0])));
  endtask

  logic [15:0] waddr [5] = '{16'h0000, 16'h00FF, 16'h0100, 16'h12AB, 16'hFFFF};
  logic [7:0]  nlo   [3] = '{8'h00, 8'h7F, 8'hFF};
  logic [7:0]  cfg_v;
  bit          finished = 0;

  initial begin
    #20;
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 strobes", int'({ale_o, ext_rd_o, ext_wr_o, ad_oe_o, ram_en_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 4; w++)
          for (int wr = 0; wr < 2; wr++) begin
            // R11: upper config bits vary with the sweep
            cfg_v = {3'(m * 3 + w + s), 1'(s), 2'(m), 2'(w)};
            for (int a = 0; a < 5; a++)
              run(cfg_v, 1'b1, 1'(wr), waddr[a], 8'(a * 37 + 5), 8'h37, 8'h00);
            for (int a = 0; a < 3; a++) begin
              run(cfg_v, 1'b0, 1'(wr), {8'hEE, nlo[a]}, 8'(a * 11 + 1), 8'h37, 8'h00);
              run(cfg_v, 1'b0, 1'(wr), {8'h00, nlo[a]}, 8'(a * 13 + 2), 8'h00, 8'h45);
            end
          end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule